// File: doc/BRIEF.md
# Serial-Loaded Wiper Position Register

This block is the digital control core of a 128-position potentiometer. A host writes a 7-bit wiper code over a three-wire serial link. The link has an active-low select, a serial clock and a data line. Bits enter a shift register most significant bit first. The contents are committed to the wiper latch when the select returns high. A serial data output passes each bit on seven shifts later, so several parts can be daisy-chained on one link.

Two more control inputs act beside the serial port. An active-low midscale input forces the wiper to centre (0x40) and clears the serial path. An active-low shutdown input opens the terminal-A switch and shorts the wiper to terminal B. During shutdown the latch keeps its value and can still be written, and the stored setting reappears once shutdown is released.

All serial and control inputs are asynchronous to the block clock. Each one is resynchronised before use. Edges of the serial clock and the select are detected in the block clock domain, so the block clock must run several times faster than the serial clock.

Top module: `serial_wiper_reg`

## Requirements
- R1: After a low level on `rst_n` at a clock edge, `wiper_code` is 0x40 and `sdo`, `sdo_en`, `term_a_open` and `wiper_short` are all 0.
- R2: While `cs_n` is low, each rising edge of `sclk` shifts `sdi` into the shift register, most significant bit first. A low-to-high transition of `cs_n` copies the register into the wiper latch, which appears on `wiper_code`.
- R3: When more than 7 bits are clocked in during one select-low frame, only the last 7 are committed. The earlier bits are dropped.
- R4: On every shift, `sdo` takes the bit that was shifted in seven shifts earlier. After the 8th shift of a frame, `sdo` shows the first bit of that frame.
- R5: Rising edges of `sclk` while `cs_n` is high change neither the shift register nor `sdo`.
- R6: While `mid_rst_n` is low, the wiper latch is forced to 0x40, and the shift register and `sdo` are cleared to 0.
- R7: A low `mid_rst_n` takes priority over a commit. When `cs_n` rises while `mid_rst_n` is low, the latch holds 0x40.
- R8: While `shdn_n` is low, `term_a_open` and `wiper_short` are 1, `sdo_en` is 0 and `wiper_code` reads 0, which is the wiper tied to terminal B.
- R9: A frame written while `shdn_n` is low still updates the latch. The new value shows on `wiper_code` once `shdn_n` returns high.
- R10: `sdo_en` is 1 exactly when `cs_n` is low and `shdn_n` is high.
- R11: A shutdown period without writes leaves the setting unchanged. After release, `wiper_code` equals its value before shutdown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used for oversampling |
| rst_n | input | 1 | Synchronous active-low block reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock; data taken on its rising edge |
| sdi | input | 1 | Serial data in |
| mid_rst_n | input | 1 | Active-low midscale preset |
| shdn_n | input | 1 | Active-low shutdown |
| sdo | output | 1 | Serial data out for daisy-chaining |
| sdo_en | output | 1 | Drive enable for the serial data output |
| wiper_code | output | 7 | Effective wiper position |
| term_a_open | output | 1 | Opens the terminal-A switch |
| wiper_short | output | 1 | Shorts the wiper to terminal B |

## Verification
A commit on the rising select and a midscale preset can fall in the same cycle. The bench provokes this by raising `cs_n` at the moment it pulls `mid_rst_n` low, after a full frame holding a non-centre code. It expects 0x40 both during the preset and after its release, with no late commit. Writes made during shutdown are judged the same way: the bench first checks that the output stays at 0 while shutdown is active, then checks after release that `wiper_code` shows the value written during shutdown.

// File: rtl/wp_pkg.sv
// Shared types and helpers for the serial wiper register.
// Assumes the wiper width is at least 2 bits.
package wp_pkg;

    // Switch and driver controls produced by the shutdown logic.
    typedef struct packed {
        logic term_open;
        logic wiper_short;
        logic sdo_en;
    } wp_sw_t;

endpackage

// File: rtl/wp_sync.sv
// Multi-stage resynchroniser for a bundle of asynchronous inputs.
// Every bit gets STAGES flops. RST_VAL gives each bit its idle level, which
// keeps reset free of false edges. Assumes STAGES >= 1.
module wp_sync #(
    parameter int            N       = 5,
    parameter int            STAGES  = 2,
    parameter logic [N-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);

    logic [N-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First flop: capture the raw asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= d;
            end
        end else begin : g_next
            // Later flops: settle metastability from the stage before.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= RST_VAL;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/wp_shifter.sv
// Serial input shift register with a registered daisy-chain output.
// Shifts MSB first on shift_en. The bit leaving the top of the register goes
// to sdo_q, so sdo shows the bit entered W shifts earlier. clear has priority
// over shifting.
module wp_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] sr_q,
    output logic         sdo_q
);

    // Shift path: clear on reset or midscale, otherwise shift when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sr_q  <= '0;
            sdo_q <= 1'b0;
        end else if (shift_en) begin
            sdo_q <= sr_q[W-1];
            sr_q  <= {sr_q[W-2:0], din};
        end
    end

endmodule

// File: rtl/wp_latch.sv
// Wiper latch. Holds the committed code. The midscale preset overrides a
// commit in the same cycle. Block reset also loads midscale.
module wp_latch #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         preset,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] code_q
);

    localparam logic [W-1:0] MIDSCALE = {1'b1, {(W-1){1'b0}}};

    // Latch update: reset and preset first, then commit.
    always_ff @(posedge clk) begin
        if (!rst_n)      code_q <= MIDSCALE;
        else if (preset) code_q <= MIDSCALE;
        else if (load)   code_q <= din;
    end

endmodule

// File: rtl/wp_switch.sv
// Shutdown and output-enable decode. Purely combinational from synchronised
// levels. In shutdown the effective wiper reads 0 (tied to terminal B) while
// the latch behind it keeps its value.
module wp_switch #(
    parameter int W = 7
) (
    input  logic              shdn_act,
    input  logic              sel_act,
    input  logic [W-1:0]      code_q,
    output wp_pkg::wp_sw_t    sw,
    output logic [W-1:0]      code_out
);

    // Decode switch controls and the visible wiper code.
    always_comb begin
        sw.term_open   = shdn_act;
        sw.wiper_short = shdn_act;
        sw.sdo_en      = sel_act && !shdn_act;
        code_out       = shdn_act ? '0 : code_q;
    end

endmodule

// File: rtl/serial_wiper_reg.sv
// Serial-loaded wiper position register (top).
// Resynchronises the serial and control inputs, detects rising edges of the
// serial clock and the select, and drives the shifter, the latch and the
// shutdown decode. Assumes clk is at least 4x faster than sclk, and that each
// input level is held for at least SYNC_STAGES+2 clk cycles.
module serial_wiper_reg #(
    parameter int W           = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_n,
    input  logic         sclk,
    input  logic         sdi,
    input  logic         mid_rst_n,
    input  logic         shdn_n,
    output logic         sdo,
    output logic         sdo_en,
    output logic [W-1:0] wiper_code,
    output logic         term_a_open,
    output logic         wiper_short
);

    localparam int           NSYNC    = 5;
    localparam logic [4:0]   SYNC_IDLE = 5'b11001;

    logic [NSYNC-1:0] raw_in, synced;
    logic cs_n_s, sclk_s, sdi_s, mid_n_s, shdn_n_s;
    logic cs_prev, sclk_prev;
    logic cs_rise, sclk_rise, cs_act, mid_act, shdn_act;
    logic [W-1:0] sr_q, code_q;
    logic sdo_q;
    wp_pkg::wp_sw_t sw;

    assign raw_in = {shdn_n, mid_rst_n, sdi, sclk, cs_n};

    wp_sync #(.N(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (synced)
    );

    assign cs_n_s   = synced[0];
    assign sclk_s   = synced[1];
    assign sdi_s    = synced[2];
    assign mid_n_s  = synced[3];
    assign shdn_n_s = synced[4];

    // Edge history for the select and the serial clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_n_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_rise   = cs_n_s && !cs_prev;
    assign sclk_rise = sclk_s && !sclk_prev;
    assign cs_act    = !cs_n_s;
    assign mid_act   = !mid_n_s;
    assign shdn_act  = !shdn_n_s;

    wp_shifter #(.W(W)) shift_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (mid_act),
        .shift_en (sclk_rise && cs_act),
        .din      (sdi_s),
        .sr_q     (sr_q),
        .sdo_q    (sdo_q)
    );

    wp_latch #(.W(W)) latch_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .preset (mid_act),
        .load   (cs_rise),
        .din    (sr_q),
        .code_q (code_q)
    );

    wp_switch #(.W(W)) switch_i (
        .shdn_act (shdn_act),
        .sel_act  (cs_act),
        .code_q   (code_q),
        .sw       (sw),
        .code_out (wiper_code)
    );

    assign sdo         = sdo_q;
    assign sdo_en      = sw.sdo_en;
    assign term_a_open = sw.term_open;
    assign wiper_short = sw.wiper_short;

endmodule

// File: rtl/wp_checker.sv
// Assertion checker for serial_wiper_reg, attached with bind below.
module wp_checker #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mid_act,
    input  logic         shdn_act,
    input  logic         cs_act,
    input  logic         cs_rise,
    input  logic [W-1:0] sr_q,
    input  logic [W-1:0] code_q,
    input  logic         sdo,
    input  logic         sdo_en,
    input  logic [W-1:0] wiper_code,
    input  logic         term_a_open,
    input  logic         wiper_short
);

    localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

    assert_midscale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mid_act |=> (code_q == MID && !sdo && sr_q == '0));

    assert_preset_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mid_act && cs_rise) |=> code_q == MID);

    assert_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && !mid_act) |=> code_q == $past(sr_q));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_act && !mid_act) |=> ($stable(sr_q) && $stable(sdo)));

    assert_shutdown_R8: assert property (@(posedge clk) disable iff (!rst_n)
        shdn_act |-> (term_a_open && wiper_short && !sdo_en && wiper_code == '0));

    assert_restore_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_act |-> (wiper_code == code_q && !term_a_open && !wiper_short));

    assert_drive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sdo_en |-> cs_act);

endmodule

bind serial_wiper_reg wp_checker #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .mid_act     (mid_act),
    .shdn_act    (shdn_act),
    .cs_act      (cs_act),
    .cs_rise     (cs_rise),
    .sr_q        (sr_q),
    .code_q      (code_q),
    .sdo         (sdo),
    .sdo_en      (sdo_en),
    .wiper_code  (wiper_code),
    .term_a_open (term_a_open),
    .wiper_short (wiper_short)
);

// File: tb/serial_wiper_reg_tb_top.sv
// Directed bench: one task per scenario, each checking its own results.
module serial_wiper_reg_tb_top;

    localparam int W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, mid_rst_n = 1'b1, shdn_n = 1'b1;
    logic sdo, sdo_en, term_a_open, wiper_short;
    logic [W-1:0] wiper_code;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #5 clk = ~clk;

    serial_wiper_reg #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .mid_rst_n(mid_rst_n), .shdn_n(shdn_n), .sdo(sdo), .sdo_en(sdo_en),
        .wiper_code(wiper_code), .term_a_open(term_a_open), .wiper_short(wiper_short)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b);
        sdi = b;  settle();
        sclk = 1'b1; settle();
        sclk = 1'b0; settle();
    endtask

    task automatic write_frame(input logic [31:0] bits, input int n);
        cs_n = 1'b0; settle();
        for (int i = n - 1; i >= 0; i--) clock_bit(bits[i]);
        cs_n = 1'b1; settle();
    endtask

    task automatic t_reset();
        chk("R1 wiper", wiper_code, 32'h40);
        chk("R1 sdo", sdo, 0);
        chk("R1 sdo_en", sdo_en, 0);
        chk("R1 term_a_open", term_a_open, 0);
        chk("R1 wiper_short", wiper_short, 0);
    endtask

    task automatic t_basic_R2();
        write_frame(32'h15, 7); chk("R2 write 0x15", wiper_code, 32'h15);
        write_frame(32'h7F, 7); chk("R2 write 0x7F", wiper_code, 32'h7F);
        write_frame(32'h00, 7); chk("R2 write 0x00", wiper_code, 32'h00);
    endtask

    task automatic t_extra_R3();
        write_frame(32'b10_1011_0011, 10);
        chk("R3 last 7 of 10", wiper_code, 32'h33);
    endtask

    task automatic t_chain_R4();
        logic [13:0] pat = 14'b10110010011101;
        cs_n = 1'b0; settle();
        chk("R10 sdo_en select low", sdo_en, 1);
        for (int k = 1; k <= 14; k++) begin
            clock_bit(pat[14 - k]);
            if (k >= 8) chk("R4 sdo delayed", sdo, pat[14 - (k - 7)]);
        end
        cs_n = 1'b1; settle();
        chk("R10 sdo_en select high", sdo_en, 0);
        chk("R3 chain last 7", wiper_code, {25'd0, pat[6:0]});
    endtask

    task automatic t_idle_R5();
        logic sdo_before;
        write_frame(32'h2A, 7);
        chk("R2 write 0x2A", wiper_code, 32'h2A);
        mid_rst_n = 1'b0; settle();
        chk("R6 preset wiper", wiper_code, 32'h40);
        chk("R6 sdo cleared", sdo, 0);
        mid_rst_n = 1'b1; settle();
        sdo_before = sdo;
        for (int i = 0; i < 9; i++) clock_bit(1'b1);
        chk("R5 sdo unchanged", sdo, sdo_before);
        chk("R5 wiper unchanged", wiper_code, 32'h40);
        cs_n = 1'b0; settle(); cs_n = 1'b1; settle();
        chk("R5 R6 register stayed clear", wiper_code, 32'h00);
    endtask

    task automatic t_prio_R7();
        cs_n = 1'b0; settle();
        for (int i = 6; i >= 0; i--) clock_bit(7'h11 >> i);
        cs_n = 1'b1; mid_rst_n = 1'b0; settle();
        chk("R7 preset over commit", wiper_code, 32'h40);
        mid_rst_n = 1'b1; settle();
        chk("R7 no late commit", wiper_code, 32'h40);
    endtask

    task automatic t_shdn();
        write_frame(32'h25, 7);
        shdn_n = 1'b0; settle();
        chk("R8 term_a_open", term_a_open, 1);
        chk("R8 wiper_short", wiper_short, 1);
        chk("R8 wiper zero", wiper_code, 0);
        cs_n = 1'b0; settle();
        chk("R8 R10 sdo_en off", sdo_en, 0);
        for (int i = 6; i >= 0; i--) clock_bit(7'h5A >> i);
        cs_n = 1'b1; settle();
        chk("R9 still zero in shutdown", wiper_code, 0);
        shdn_n = 1'b1; settle();
        chk("R9 new value after release", wiper_code, 32'h5A);
        chk("R8 switches released", {term_a_open, wiper_short}, 0);
        shdn_n = 1'b0; settle();
        shdn_n = 1'b1; settle();
        chk("R11 setting kept", wiper_code, 32'h5A);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_basic_R2();
        t_extra_R3();
        t_chain_R4();
        t_idle_R5();
        t_prio_R7();
        t_shdn();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule